// File: doc/BRIEF.md
# Burst re-arbitration point generator

This block sits beside one slave port of a bus interconnect. It watches the transfers a master presents to that slave and tells the slave's arbiter when it may hand the slave to another master in the middle of a burst. It has two triggers. The first cuts undefined-length incrementing bursts into pieces of a selectable beat count by raising a predicted end of burst. The second is a per-slave budget of clock cycles that starts when an access begins. When the budget is used up, the access is broken at the next completed beat.

The arbiter samples `rearb_ok` in the cycle in which a beat is accepted. A high level there means the arbiter may re-arbitrate once that beat has completed. `pred_eob` says that the same beat closes a beat boundary of an undefined-length burst. Both outputs are combinational from the current inputs and the counter state. They never assert in a cycle that has no accepted beat.

Top module: `burst_rearb_gen`

## Requirements
- R1: After a synchronous active-low reset, both counters are cleared and the slot limit is disarmed. A SEQ beat accepted right after reset (sel = 4, slot value 1) gives `pred_eob` = 0 and `rearb_ok` = 0.
- R2: With `len_sel` = 0 (infinite), and with the unused codes 5, 6 and 7, `pred_eob` is never asserted.
- R3: With `len_sel` = 1, every accepted beat of an INCR burst (`burst_type` = 3'b001) asserts `pred_eob`.
- R4: With `len_sel` = 2, 3 or 4, `pred_eob` is asserted on the accepted INCR beats numbered 4k, 8k or 16k respectively. Beat 1 is the beat accepted while `burst_start` is high.
- R5: `pred_eob` is asserted only when `burst_type` = 3'b001 (INCR). Every other burst type leaves it low.
- R6: Every new burst start, and any cycle with `trans_type` = 2'b00 (IDLE), restarts the beat numbering. A beat is accepted when `beat_ok` = 1 and `trans_type` is 2'b10 (NONSEQ) or 2'b11 (SEQ). 2'b01 (BUSY) accepts no beat and holds the beat count.
- R7: Each cycle with `burst_start` high loads the slot counter with `slot_cfg`. Every later non-IDLE cycle lowers it by one. An accepted non-start beat in a cycle at least `slot_cfg`+1 cycles after the last start cycle asserts `rearb_ok`. The start beat never fires on the slot limit.
- R8: A `slot_cfg` of 0 loaded at burst start disables the slot limit for that burst, so `rearb_ok` follows `pred_eob` alone.
- R9: `rearb_ok` is high exactly in cycles with an accepted beat for which `pred_eob` is high or the slot limit has expired. It is a one-cycle pulse per such beat.
- R10: The slot counter saturates at zero and does not wrap. Once expired, every further accepted beat of the same burst asserts `rearb_ok`, even hundreds of cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trans_type | input | 2 | Transfer type: 00 IDLE, 01 BUSY, 10 NONSEQ, 11 SEQ |
| burst_type | input | 3 | Burst type; 3'b001 is an undefined-length incrementing burst |
| beat_ok | input | 1 | Slave has accepted the current beat this cycle |
| burst_start | input | 1 | Current transfer is the first of a new burst |
| len_sel | input | 3 | Beat boundary: 0 infinite, 1 one, 2 four, 3 eight, 4 sixteen, 5-7 infinite |
| slot_cfg | input | SLOT_W | Slot cycle budget, 0 disables |
| rearb_ok | output | 1 | Arbiter may re-arbitrate after this beat |
| pred_eob | output | 1 | This beat closes a predicted end of burst |

## Verification
Both results are due in the same cycle as the accepted beat that causes them, with no register on the path. The counters they depend on change only at the clock edge that ends that cycle. The slot expiry is due `slot_cfg`+1 cycles after the last start cycle. The bench drives every input on the falling edge and compares both outputs 5 ns later, still ahead of the next rising edge. Its reference model then advances its own counters, as the design does at that edge. Random bursts with wait states, BUSY cycles, mixed burst types and all eight `len_sel` codes are mixed with directed cases for reset, restart after IDLE and a burst longer than the counter range.

// File: rtl/burst_rearb_pkg.sv
// Package: shared transfer encodings for the burst re-arbitration block.
// Assumes the usual two-bit transfer type and three-bit burst type coding.
package burst_rearb_pkg;

    typedef enum logic [1:0] {
        TR_IDLE   = 2'b00,
        TR_BUSY   = 2'b01,
        TR_NONSEQ = 2'b10,
        TR_SEQ    = 2'b11
    } trans_e;

    typedef enum logic [2:0] {
        LEN_INF   = 3'd0,
        LEN_ONE   = 3'd1,
        LEN_FOUR  = 3'd2,
        LEN_EIGHT = 3'd3,
        LEN_SIXT  = 3'd4
    } len_sel_e;

    localparam logic [2:0] BURST_INCR = 3'b001;

endpackage

// File: rtl/rearb_len_decode.sv
// Module: turns the burst-length selection into a boundary enable and a
// power-of-two mask on the beat number. Codes above sixteen are infinite.
// Assumes CNT_W is at least 4 so the sixteen-beat mask fits.
module rearb_len_decode #(
    parameter int CNT_W = 4
) (
    input  logic [2:0]       len_sel,
    output logic             bound_en,
    output logic [CNT_W-1:0] bound_mask
);
    import burst_rearb_pkg::*;

    // Purpose: map each selection code to its boundary mask.
    always_comb begin
        bound_en   = 1'b1;
        bound_mask = '0;
        case (len_sel)
            LEN_ONE:   bound_mask = '0;
            LEN_FOUR:  bound_mask = CNT_W'(3);
            LEN_EIGHT: bound_mask = CNT_W'(7);
            LEN_SIXT:  bound_mask = CNT_W'(15);
            default: begin
                bound_en   = 1'b0;
                bound_mask = '0;
            end
        endcase
    end

endmodule

// File: rtl/rearb_beat_tracker.sv
// Module: numbers the accepted beats of the current burst. It flags the
// beats that close a selected boundary inside an incrementing burst. The
// count wraps modulo 2**CNT_W, and every supported boundary divides that.
// Assumes start is high on the first transfer of each burst.
module rearb_beat_tracker #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idle,
    input  logic             accept,
    input  logic             start,
    input  logic             is_incr,
    input  logic             bound_en,
    input  logic [CNT_W-1:0] bound_mask,
    output logic             at_bound
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] beat_num;

    // Purpose: number of the beat presented now (1 for a start beat).
    assign beat_num = start ? CNT_W'(1) : cnt_q + CNT_W'(1);

    // Purpose: keep the number of the last accepted beat; clear on idle or start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (idle) begin
            cnt_q <= '0;
        end else if (accept) begin
            cnt_q <= beat_num;
        end else if (start) begin
            cnt_q <= '0;
        end
    end

    // Purpose: flag an accepted incrementing beat that lands on a boundary.
    assign at_bound = accept && is_incr && bound_en
                      && ((beat_num & bound_mask) == '0);

endmodule

// File: rtl/rearb_slot_timer.sv
// Module: per-access cycle budget. It loads on every start cycle, counts
// down once per non-idle cycle and holds at zero. A loaded value of zero
// leaves the timer disarmed.
// Assumes idle takes priority over start.
module rearb_slot_timer #(
    parameter int SLOT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idle,
    input  logic              start,
    input  logic [SLOT_W-1:0] slot_cfg,
    output logic              expired
);
    logic [SLOT_W-1:0] slot_q;
    logic              armed_q;

    // Purpose: load, count down with saturation, or clear the budget.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q  <= '0;
            armed_q <= 1'b0;
        end else if (idle) begin
            slot_q  <= '0;
            armed_q <= 1'b0;
        end else if (start) begin
            slot_q  <= slot_cfg;
            armed_q <= (slot_cfg != '0);
        end else if (slot_q != '0) begin
            slot_q  <= slot_q - SLOT_W'(1);
        end
    end

    // Purpose: the budget is used up only when it was armed.
    assign expired = armed_q && (slot_q == '0);

endmodule

// File: rtl/burst_rearb_gen.sv
// Module: top of the re-arbitration point generator. It combines the beat
// boundary and the slot budget into one pulse per accepted beat.
// Assumes burst_start coincides with NONSEQ transfers and that beat_ok
// marks the cycle in which the slave completes the presented beat.
module burst_rearb_gen #(
    parameter int SLOT_W    = 8,
    parameter int MAX_BEATS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        trans_type,
    input  logic [2:0]        burst_type,
    input  logic              beat_ok,
    input  logic              burst_start,
    input  logic [2:0]        len_sel,
    input  logic [SLOT_W-1:0] slot_cfg,
    output logic              rearb_ok,
    output logic              pred_eob
);
    import burst_rearb_pkg::*;

    localparam int CNT_W = (MAX_BEATS < 16) ? 4 : $clog2(MAX_BEATS);

    logic             bus_idle;
    logic             beat_acc;
    logic             incr_burst;
    logic             bound_en;
    logic [CNT_W-1:0] bound_mask;
    logic             at_bound;
    logic             slot_expired;
    logic             slot_fire;

    // Purpose: qualify the transfer-level conditions.
    assign bus_idle   = (trans_type == TR_IDLE);
    assign beat_acc   = beat_ok && trans_type[1];
    assign incr_burst = (burst_type == BURST_INCR);

    rearb_len_decode #(.CNT_W(CNT_W)) u_dec (
        .len_sel    (len_sel),
        .bound_en   (bound_en),
        .bound_mask (bound_mask)
    );

    rearb_beat_tracker #(.CNT_W(CNT_W)) u_beat (
        .clk        (clk),
        .rst_n      (rst_n),
        .idle       (bus_idle),
        .accept     (beat_acc),
        .start      (burst_start),
        .is_incr    (incr_burst),
        .bound_en   (bound_en),
        .bound_mask (bound_mask),
        .at_bound   (at_bound)
    );

    rearb_slot_timer #(.SLOT_W(SLOT_W)) u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .idle     (bus_idle),
        .start    (burst_start),
        .slot_cfg (slot_cfg),
        .expired  (slot_expired)
    );

    // Purpose: a slot break applies only to a completed beat after the start one.
    assign slot_fire = beat_acc && !burst_start && slot_expired;

    // Purpose: drive the two outputs.
    assign pred_eob = at_bound;
    assign rearb_ok = at_bound || slot_fire;

endmodule

// File: rtl/burst_rearb_checker.sv
// Module: property checker for burst_rearb_gen, attached through bind.
// Assumes the default encodings from burst_rearb_pkg.
module burst_rearb_checker #(
    parameter int SLOT_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        trans_type,
    input logic [2:0]        burst_type,
    input logic              beat_ok,
    input logic              burst_start,
    input logic [2:0]        len_sel,
    input logic [SLOT_W-1:0] slot_cfg,
    input logic              rearb_ok,
    input logic              pred_eob,
    input logic              slot_expired
);
    logic acc;
    assign acc = beat_ok && trans_type[1];

    assert_quiet_without_beat_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |-> (!rearb_ok && !pred_eob));

    assert_eob_implies_rearb_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pred_eob |-> rearb_ok);

    assert_no_eob_infinite_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (len_sel == 3'd0 || len_sel > 3'd4) |-> !pred_eob);

    assert_eob_every_beat_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && burst_type == 3'b001 && len_sel == 3'd1) |-> pred_eob);

    assert_first_beat_no_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && burst_start && len_sel >= 3'd2 && len_sel <= 3'd4) |-> !pred_eob);

    assert_incr_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_type != 3'b001) |-> !pred_eob);

    assert_start_beat_no_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && burst_start && !pred_eob) |-> !rearb_ok);

    assert_zero_slot_disarms_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_start && slot_cfg == '0 && trans_type != 2'b00) |=> !slot_expired);

    assert_slot_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_expired && trans_type != 2'b00 && !burst_start) |=> slot_expired);

endmodule

bind burst_rearb_gen burst_rearb_checker #(.SLOT_W(SLOT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .trans_type   (trans_type),
    .burst_type   (burst_type),
    .beat_ok      (beat_ok),
    .burst_start  (burst_start),
    .len_sel      (len_sel),
    .slot_cfg     (slot_cfg),
    .rearb_ok     (rearb_ok),
    .pred_eob     (pred_eob),
    .slot_expired (slot_expired)
);

// File: tb/burst_rearb_gen_tb.sv
// Bench: random bursts plus directed corner cases, checked against a
// reference model written from the requirements.
module burst_rearb_gen_tb_top;
    localparam int SLOT_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        trans_type = 2'b00;
    logic [2:0]        burst_type = 3'b001;
    logic              beat_ok = 1'b0;
    logic              burst_start = 1'b0;
    logic [2:0]        len_sel = 3'd0;
    logic [SLOT_W-1:0] slot_cfg = '0;
    logic              rearb_ok;
    logic              pred_eob;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // reference model state
    int  m_cnt = 0;
    int  m_slot = 0;
    bit  m_armed = 1'b0;
    int  m_age = 0;

    always #10 clk = ~clk;

    burst_rearb_gen #(.SLOT_W(SLOT_W), .MAX_BEATS(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .trans_type(trans_type), .burst_type(burst_type),
        .beat_ok(beat_ok), .burst_start(burst_start), .len_sel(len_sel),
        .slot_cfg(slot_cfg), .rearb_ok(rearb_ok), .pred_eob(pred_eob)
    );

    function automatic int boundary(input logic [2:0] sel);
        case (sel)
            3'd1: return 1;
            3'd2: return 4;
            3'd3: return 8;
            3'd4: return 16;
            default: return 0;
        endcase
    endfunction

    task automatic check(input bit got, input bit exp, input string tag, input string what);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, got, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        m_cnt = 0; m_slot = 0; m_armed = 1'b0; m_age = 0;
        rst_n = 1'b1;
    endtask

    // One cycle: drive at the falling edge, compare, then advance the model.
    task automatic step(input logic [1:0] tr, input logic [2:0] bu, input bit ok,
                        input bit st, input string ovr);
        bit acc, e_pe, e_ra, expd;
        int k, n;
        string tpe, tra;
        @(negedge clk);
        trans_type = tr; burst_type = bu; beat_ok = ok; burst_start = st;
        #5;
        acc  = ok && tr[1];
        k    = st ? 1 : m_cnt + 1;
        n    = boundary(len_sel);
        e_pe = acc && (bu == 3'b001) && (n > 0) && ((k % n) == 0);
        expd = m_armed && (m_slot == 0);
        e_ra = e_pe || (acc && !st && expd);
        if (bu != 3'b001) tpe = "R5";
        else if (len_sel == 3'd1) tpe = "R3";
        else if (len_sel >= 3'd2 && len_sel <= 3'd4) tpe = "R4";
        else tpe = "R2";
        if (!acc || e_pe) tra = "R9";
        else if (!m_armed) tra = "R8";
        else if (m_age > 200) tra = "R10";
        else tra = "R7";
        if (ovr != "") begin tpe = ovr; tra = ovr; end
        check(pred_eob, e_pe, tpe, "pred_eob");
        check(rearb_ok, e_ra, tra, "rearb_ok");
        if (tr == 2'b00) begin
            m_cnt = 0; m_slot = 0; m_armed = 1'b0; m_age = 0;
        end else begin
            if (acc) m_cnt = k;
            if (st) begin
                m_slot = int'(slot_cfg); m_armed = (slot_cfg != '0); m_age = 0;
            end else begin
                if (m_slot > 0) m_slot--;
                m_age++;
            end
        end
    endtask

    // A burst with optional wait states and BUSY cycles.
    task automatic burst(input int len, input logic [2:0] bu, input logic [2:0] sel,
                         input int cfg, input int wpct, input int bpct, input string ovr);
        len_sel = sel;
        slot_cfg = SLOT_W'(cfg);
        for (int i = 0; i < len; i++) begin
            if (i > 0 && ($urandom % 100) < bpct)
                step(2'b01, bu, 1'($urandom % 2), 1'b0, ovr);
            while (($urandom % 100) < wpct)
                step(i == 0 ? 2'b10 : 2'b11, bu, 1'b0, i == 0, ovr);
            step(i == 0 ? 2'b10 : 2'b11, bu, 1'b1, i == 0, ovr);
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240607));
        // R1: expire the slot, reset mid-burst, then a SEQ beat must be quiet
        rst_n = 1'b1;
        do_reset();
        burst(5, 3'b001, 3'd4, 1, 0, 0, "");
        do_reset();
        len_sel = 3'd4; slot_cfg = SLOT_W'(1);
        step(2'b11, 3'b001, 1'b1, 1'b0, "R1");
        step(2'b00, 3'b001, 1'b0, 1'b0, "R1");
        // R3 / R4 / R2 directed across every selection code
        for (int s = 0; s < 8; s++) begin
            burst(34, 3'b001, 3'(s), 0, 0, 0, "");
            step(2'b00, 3'b001, 1'b0, 1'b0, "");
        end
        // R5: non-INCR burst types
        burst(16, 3'b011, 3'd1, 0, 20, 10, "R5");
        burst(16, 3'b000, 3'd2, 0, 20, 10, "R5");
        // R6: short burst, idle, new burst restarts numbering; back-to-back start too
        burst(3, 3'b001, 3'd2, 0, 0, 0, "R6");
        step(2'b00, 3'b001, 1'b0, 1'b0, "R6");
        burst(5, 3'b001, 3'd2, 0, 0, 0, "R6");
        burst(6, 3'b001, 3'd2, 0, 0, 30, "R6");
        // R7 / R8: slot expiry with and without a budget
        burst(12, 3'b101, 3'd0, 4, 30, 20, "R7");
        burst(12, 3'b101, 3'd0, 0, 30, 20, "R8");
        // R10: long burst past the counter range
        burst(300, 3'b001, 3'd0, 1, 10, 5, "R10");
        step(2'b00, 3'b001, 1'b0, 1'b0, "");
        // random mix
        for (int b = 0; b < 400; b++) begin
            int len, cfg, idl;
            logic [2:0] bu;
            len = 1 + int'($urandom % 40);
            bu  = (($urandom % 4) != 0) ? 3'b001 : 3'($urandom % 8);
            cfg = (($urandom % 4) == 0) ? 0 : int'($urandom % 30);
            burst(len, bu, 3'($urandom % 8), cfg, int'($urandom % 40), int'($urandom % 20), "");
            idl = int'($urandom % 3);
            for (int j = 0; j < idl; j++) step(2'b00, 3'b001, 1'($urandom % 2), 1'b0, "");
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule